// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit carries out the execution step of a bit-manipulation instruction. It takes a destination operand, a bit number, a flag that says whether the destination is a data register or a byte in memory, and one of four operations: test, set, clear or invert. Every operation first samples the selected bit. The zero flag then reports whether that bit was 0 before any change was made.

The operation result, a write-enable and the updated flag word are registered. They appear one clock after a valid input, together with a one-cycle done pulse. A register destination uses the full 32-bit word, and the bit number is reduced modulo 32. A memory destination uses only the low byte of the operand, and the bit number is reduced modulo 8. The surrounding core fetches the operands, performs any bus cycles and writes the result back when the write-enable is high.

Top module: `bit_modify_unit`

## Requirements
- R1: Operation code 3 (set) returns the destination with the selected bit forced to 1.
- R2: Operation code 2 (clear) returns the destination with the selected bit forced to 0.
- R3: Operation code 1 (invert) returns the destination with the selected bit complemented.
- R4: Operation code 0 (test) returns the destination unchanged, and out_wr_en stays 0 for it. Codes 1, 2 and 3 assert out_wr_en together with out_done.
- R5: Flag bit 2 (zero) of out_flags is 1 when the selected bit was 0 before the operation, and 0 when it was 1.
- R6: Flag bits 4, 3, 1 and 0 of out_flags equal the corresponding bits of in_flags that were presented with the operation.
- R7: When in_is_mem is 0, the bit index is in_bitnum modulo 32 and all 32 operand bits take part.
- R8: When in_is_mem is 1, the bit index is in_bitnum modulo 8. Only in_operand[7:0] is used, and out_value[31:8] is 0.
- R9: out_done is high for exactly the one cycle after a cycle with in_valid high. out_value, out_flags and out_wr_en belong to that operation. out_wr_en is never high without out_done.
- R10: After reset, out_done, out_wr_en, out_value and out_flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request for this cycle |
| in_operand | input | 32 | Destination value (low byte used for memory) |
| in_bitnum | input | 8 | Bit number before reduction |
| in_is_mem | input | 1 | 1 = memory byte destination, 0 = data register |
| in_op | input | 2 | 0 test, 1 invert, 2 clear, 3 set |
| in_flags | input | 5 | Current flags {X,N,Z,V,C} |
| out_done | output | 1 | Result valid pulse |
| out_value | output | 32 | Resulting destination value |
| out_wr_en | output | 1 | Write the result back |
| out_flags | output | 5 | Flags with zero replaced |

## Verification
Each operation runs on a selected bit that was 0 and on one that was 1. This separates the pre-modification zero flag from a flag taken after the change, and it shows whether set and clear are idempotent. Bit numbers 31, 37 and 11, given in both register and memory kind, show whether the modulo reduction depends on the kind. Memory operands carry non-zero upper bytes to expose any leak past the byte lane. Distinct flag patterns and back-to-back requests check pass-through of the other flags and the single-cycle done pulse.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [1:0] {
    BOP_TEST  = 2'd0,
    BOP_FLIP  = 2'd1,
    BOP_CLEAR = 2'd2,
    BOP_SET   = 2'd3
  } bop_e;

  localparam int FLAG_W = 5;
  localparam int FLAG_Z = 2;
endpackage

// File: rtl/bmu_mask_gen.sv
module bmu_mask_gen #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int NUM_W  = 8
) (
  input  logic [NUM_W-1:0]  bitnum,
  input  logic              is_mem,
  output logic [DATA_W-1:0] bit_mask,
  output logic [DATA_W-1:0] lane_mask
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int BIDX_W = $clog2(BYTE_W);

  logic [IDX_W-1:0] sel_idx;
  logic             unused_hi_bits;

  assign unused_hi_bits = ^bitnum;

  // register kind keeps the word index, memory kind keeps the byte index
  always_comb begin
    if (is_mem)
      sel_idx = {{(IDX_W-BIDX_W){1'b0}}, bitnum[BIDX_W-1:0]};
    else
      sel_idx = bitnum[IDX_W-1:0];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign bit_mask[i] = (sel_idx == IDX_W'(i));
    if (i < BYTE_W) begin : g_low
      assign lane_mask[i] = 1'b1;
    end else begin : g_high
      assign lane_mask[i] = ~is_mem;
    end
  end
endmodule

// File: rtl/bmu_alu.sv
module bmu_alu
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] bit_mask,
  input  logic [DATA_W-1:0] lane_mask,
  input  bop_e              op,
  output logic [DATA_W-1:0] result,
  output logic              old_bit,
  output logic              writes
);
  logic [DATA_W-1:0] base;

  assign base    = operand & lane_mask;
  assign old_bit = |(base & bit_mask);

  always_comb begin
    unique case (op)
      BOP_SET:   begin result = base | bit_mask;  writes = 1'b1; end
      BOP_CLEAR: begin result = base & ~bit_mask; writes = 1'b1; end
      BOP_FLIP:  begin result = base ^ bit_mask;  writes = 1'b1; end
      default:   begin result = base;             writes = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int NUM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [NUM_W-1:0]  in_bitnum,
  input  logic              in_is_mem,
  input  logic [1:0]        in_op,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_done,
  output logic [DATA_W-1:0] out_value,
  output logic              out_wr_en,
  output logic [FLAG_W-1:0] out_flags
);
  logic [DATA_W-1:0] bit_mask, lane_mask, result;
  logic              old_bit, writes;
  logic [FLAG_W-1:0] next_flags;

  bmu_mask_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_W(NUM_W)) u_mask (
    .bitnum   (in_bitnum),
    .is_mem   (in_is_mem),
    .bit_mask (bit_mask),
    .lane_mask(lane_mask)
  );

  bmu_alu #(.DATA_W(DATA_W)) u_alu (
    .operand  (in_operand),
    .bit_mask (bit_mask),
    .lane_mask(lane_mask),
    .op       (bop_e'(in_op)),
    .result   (result),
    .old_bit  (old_bit),
    .writes   (writes)
  );

  always_comb begin
    next_flags         = in_flags;
    next_flags[FLAG_Z] = ~old_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done  <= 1'b0;
      out_wr_en <= 1'b0;
      out_value <= '0;
      out_flags <= '0;
    end else begin
      out_done  <= in_valid;
      out_wr_en <= in_valid & writes;
      if (in_valid) begin
        out_value <= result;
        out_flags <= next_flags;
      end
    end
  end
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_operand,
  input logic              in_is_mem,
  input logic [1:0]        in_op,
  input logic [FLAG_W-1:0] in_flags,
  input logic              out_done,
  input logic [DATA_W-1:0] out_value,
  input logic              out_wr_en,
  input logic [FLAG_W-1:0] out_flags
);
  a_r9_done_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_done);

  a_r9_done_needs_req: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_done);

  a_r9_wr_only_done: assert property (@(posedge clk) disable iff (rst)
    out_wr_en |-> out_done);

  a_r4_test_no_write: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'd0 && !in_is_mem) |=> (!out_wr_en && out_value == $past(in_operand)));

  a_r6_flags_pass: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_flags[4:3] == $past(in_flags[4:3]) && out_flags[1:0] == $past(in_flags[1:0])));

  a_r8_byte_lane: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_is_mem) |=> (out_value[DATA_W-1:8] == '0));
endmodule

bind bit_modify_unit bmu_checker #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
  .in_is_mem(in_is_mem), .in_op(in_op), .in_flags(in_flags),
  .out_done(out_done), .out_value(out_value), .out_wr_en(out_wr_en),
  .out_flags(out_flags)
);

// File: tb/sim_bit_modify_unit.sv
`timescale 1ns/1ps
module sim_bit_modify_unit;
  logic        clk = 0, rst = 1, in_valid = 0, in_is_mem = 0;
  logic [31:0] in_operand = 0;
  logic [7:0]  in_bitnum = 0;
  logic [1:0]  in_op = 0;
  logic [4:0]  in_flags = 0;
  logic        out_done, out_wr_en;
  logic [31:0] out_value;
  logic [4:0]  out_flags;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  bit_modify_unit u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [1:0] op, logic [31:0] opnd,
                        logic [7:0] num, logic mem, logic [4:0] fl);
    logic [31:0] base, exp_v;
    int idx;
    logic old;
    base  = mem ? {24'h0, opnd[7:0]} : opnd;
    idx   = mem ? int'(num % 8) : int'(num % 32);
    old   = base[idx];
    exp_v = base;
    case (op)
      2'd3: exp_v[idx] = 1'b1;
      2'd2: exp_v[idx] = 1'b0;
      2'd1: exp_v[idx] = ~old;
      default: ;
    endcase
    @(negedge clk);
    in_valid = 1; in_op = op; in_operand = opnd; in_bitnum = num;
    in_is_mem = mem; in_flags = fl;
    @(negedge clk);
    in_valid = 0;
    chk({req, " value"}, out_value, exp_v);
    chk({req, " R5 zero"}, {31'h0, out_flags[2]}, {31'h0, ~old});
    chk({req, " R6 flags"}, {27'h0, out_flags[4:3], 1'b0, out_flags[1:0]},
        {27'h0, fl[4:3], 1'b0, fl[1:0]});
    chk({req, " R4 wr_en"}, {31'h0, out_wr_en}, {31'h0, op != 2'd0});
    chk({req, " R9 done"}, {31'h0, out_done}, 32'h1);
    @(negedge clk);
    chk({req, " R9 done drop"}, {31'h0, out_done}, 32'h0);
    chk({req, " R9 wr drop"}, {31'h0, out_wr_en}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R10 done", {31'h0, out_done}, 0);
    chk("R10 wr", {31'h0, out_wr_en}, 0);
    chk("R10 value", out_value, 0);
    chk("R10 flags", {27'h0, out_flags}, 0);
  endtask

  task automatic t_set;
    run_op("R1 set zero bit", 2'd3, 32'h0000_0000, 8'd5, 0, 5'b10011);
    run_op("R1 set one bit", 2'd3, 32'h8000_0020, 8'd5, 0, 5'b01000);
  endtask

  task automatic t_clear;
    run_op("R2 clear msb", 2'd2, 32'hFFFF_FFFF, 8'd31, 0, 5'b11111);
    run_op("R2 clear zero bit", 2'd2, 32'h1234_5670, 8'd0, 0, 5'b00000);
  endtask

  task automatic t_flip;
    run_op("R3 flip 0->1", 2'd1, 32'hA5A5_A5A5, 8'd1, 0, 5'b10100);
    run_op("R3 flip 1->0", 2'd1, 32'hA5A5_A5A5, 8'd0, 0, 5'b00011);
  endtask

  task automatic t_test;
    run_op("R4 test one", 2'd0, 32'hDEAD_BEEF, 8'd3, 0, 5'b11011);
    run_op("R4 test zero", 2'd0, 32'hDEAD_BEEF, 8'd4, 0, 5'b00100);
  endtask

  task automatic t_modulo;
    run_op("R7 reg num 37", 2'd3, 32'h0000_0000, 8'd37, 0, 5'b01010);
    run_op("R7 reg num 255", 2'd2, 32'hFFFF_FFFF, 8'd255, 0, 5'b00001);
    run_op("R8 mem num 11", 2'd3, 32'hFFFF_FF00, 8'd11, 1, 5'b10000);
    run_op("R8 mem num 7 test", 2'd0, 32'h1234_5680, 8'd7, 1, 5'b01001);
    run_op("R8 mem num 31 flip", 2'd1, 32'hFFFF_FFFF, 8'd31, 1, 5'b00110);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_valid = 1; in_op = 2'd3; in_operand = 0; in_bitnum = 8'd2; in_is_mem = 0; in_flags = 0;
    @(negedge clk);
    chk("R9 b2b first", out_value, 32'h4);
    in_op = 2'd1; in_bitnum = 8'd9; in_operand = 32'h200;
    @(negedge clk);
    in_valid = 0;
    chk("R9 b2b second", out_value, 32'h0);
    chk("R9 b2b done held", {31'h0, out_done}, 1);
    @(negedge clk);
    chk("R9 b2b done drop", {31'h0, out_done}, 0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_set();
    t_clear();
    t_flip();
    t_test();
    t_modulo();
    t_back_to_back();
    finish_run();
  end
endmodule